// File: doc/BRIEF.md
# Table-Lookup Decimal Digit Arithmetic Unit

This block adds, subtracts and multiplies decimal fields one digit at a time and has no adder in its datapath. Every result digit is read from a table in an external, digit-addressed core memory. The sum table holds 100 digits at addresses 300 to 399. The product table holds 200 digits at addresses 100 to 299. For each operand digit pair the unit forms a table address, issues one read, waits the memory's fixed latency and captures the digit. A carry coming in from the lower digit is folded in by a second read of the sum table, with the carry as one of the two operand digits.

A caller pulses `start` with an operation code. It then offers digit pairs on a valid/ready handshake, least significant digit first, and flags the most significant pair with `dig_last`. Results leave on a one-cycle-valid result port, low digit first. Subtraction adds the nines' complement of the subtrahend with an initial carry of one. The digits are held until the field ends. When there is no final carry, the unit re-reads the table to recomplement them and emits the magnitude marked negative. Multiplication takes a multi-digit field times one multiplier digit and emits one extra top digit.

The controller has seven states:
- IDLE: waits for a valid start and leaves to GET.
- GET: holds `dig_ready` high and leaves to RD when a pair is accepted.
- RD: issues a read and goes to WAIT.
- WAIT: counts out the latency and goes to EVAL.
- EVAL: consumes the digit. It returns to RD for the next lookup of the same pair, or goes to PUT to emit a result. For subtraction it goes to GET for more digits, or to SOUT once the field ends.
- SOUT: fetches a stored difference digit. It goes to RD for recomplementing, or straight to PUT.
- PUT: drives one result. It loops in PUT for the product's top digit, and otherwise goes to GET, SOUT or IDLE.

Top module: `lut_decimal_alu`

## Requirements
- R1: After reset `busy`, `dig_ready`, `mem_rd_en` and `res_valid` are all 0.
- R2: With `op_sel`=0 (add) each result digit equals (a + b + carry-in) mod 10, and every read made for add or subtract lies in digit addresses 300..399. The sum-table digit at 300+10x+y is (x+y) mod 10.
- R3: With `op_sel`=2 (multiply) every product-table read lies in 100..299. The low product digit of x*y is read at 100+2*(10x+y) and the high digit at the next address.
- R4: Carries propagate from low to high digit. An add whose total exceeds the field raises `res_carry` together with its last result digit, and `res_carry` is 0 on every other result.
- R5: With `op_sel`=1 (subtract) a non-negative difference a-b is emitted as n digits with `res_neg`=0.
- R6: A negative difference is emitted as the n-digit magnitude |a-b| with `res_neg`=1 on every digit.
- R7: Multiplying an n-digit field by the single digit on `dig_b` emits n+1 digits. The final digit is the outgoing carry.
- R8: Read data is captured exactly MEM_LAT cycles after the cycle in which `mem_rd_en` is high, and no read is issued while one is outstanding.
- R9: `busy` rises in the cycle after an accepted start and stays high through the last result digit. A start with code 3, or any start while busy, is ignored.
- R10: `dig_ready` is high only while the unit waits for a digit pair. A pair held valid while ready is low is not taken twice.
- R11: A field reaching MAX_DIGITS (8) pairs ends after the MAX_DIGITS-th pair even without `dig_last`.
- R12: Every emitted result digit is in 0..9, and `res_last` marks only the final result of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled in IDLE) |
| op_sel | input | 2 | 0 add, 1 subtract, 2 multiply, 3 ignored |
| busy | output | 1 | Operation in progress |
| dig_valid | input | 1 | Operand digit pair offered |
| dig_ready | output | 1 | Unit accepts a digit pair this cycle |
| dig_a | input | 4 | First operand digit (augend, minuend or multiplicand) |
| dig_b | input | 4 | Second operand digit (multiplier digit for multiply) |
| dig_last | input | 1 | Pair is the most significant of the field |
| mem_rd_en | output | 1 | Table read request |
| mem_rd_addr | output | ADDR_W (15) | Digit address of the read |
| mem_rd_data | input | 4 | Digit returned MEM_LAT cycles after the request |
| res_valid | output | 1 | Result digit present (one cycle per digit) |
| res_digit | output | 4 | Result digit |
| res_last | output | 1 | Final result digit of the operation |
| res_carry | output | 1 | Add overflow, with the last digit |
| res_neg | output | 1 | Result is a negative difference magnitude |

## Verification
The embedded properties check the following on every cycle:
- every sum-table and product-table address stays inside its window;
- a read is never issued while another is in flight, and `dig_ready` never coincides with a pending read;
- results appear only while busy and never exceed nine;
- a start during an operation leaves the latched operation untouched;
- the digit counter never passes the field limit.

Whether the table digits are combined correctly can only be shown by the bench's scenarios, which compare every result against integer arithmetic. That covers carry ripple through nines, the negative-difference recomplement pass, the extra product digit, the truncated field and the capture timing of the latency pipeline.

// File: rtl/dlu_pkg.sv
package dlu_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        LK_SUM = 2'd0,
        LK_PLO = 2'd1,
        LK_PHI = 2'd2
    } lk_e;

    typedef enum logic [2:0] {
        PH_SUM, PH_CIN, PH_MLO, PH_MHI, PH_MCIN, PH_MCY, PH_FIX
    } ph_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_GET, ST_RD, ST_WAIT, ST_EVAL, ST_PUT, ST_SOUT
    } st_e;

    localparam logic [3:0] DIGIT_TOP = 4'd9;
endpackage

// File: rtl/dlu_addr_gen.sv
module dlu_addr_gen
    import dlu_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int ADD_BASE = 300,
    parameter int MUL_BASE = 100
)(
    input  lk_e               kind,
    input  logic [3:0]        x,
    input  logic [3:0]        y,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] pair_idx;

    always_comb begin
        pair_idx = (ADDR_W'(x) << 3) + (ADDR_W'(x) << 1) + ADDR_W'(y);
        unique case (kind)
            LK_SUM:  addr = ADDR_W'(ADD_BASE) + pair_idx;
            LK_PLO:  addr = ADDR_W'(MUL_BASE) + (pair_idx << 1);
            default: addr = ADDR_W'(MUL_BASE) + (pair_idx << 1) + ADDR_W'(1);
        endcase
    end
endmodule

// File: rtl/dlu_rd_timer.sv
module dlu_rd_timer #(
    parameter int LAT = 2
)(
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    output logic pending,
    output logic done
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
            left_q  <= '0;
        end else if (issue) begin
            pending <= 1'b1;
            left_q  <= CW'(LAT - 1);
        end else if (pending) begin
            if (left_q == '0) pending <= 1'b0;
            else              left_q  <= left_q - 1'b1;
        end
    end

    assign done = pending && (left_q == '0);

    // R8
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !pending);
endmodule

// File: rtl/dlu_digit_store.sv
module dlu_digit_store #(
    parameter int DEPTH = 8,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [3:0]    wdata,
    input  logic [IW-1:0] ridx,
    output logic [3:0]    rdata
);
    logic [3:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[widx] <= wdata;
    end

    assign rdata = cells[ridx];
endmodule

// File: rtl/lut_decimal_alu.sv
module lut_decimal_alu
    import dlu_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int ADD_BASE   = 300,
    parameter int MUL_BASE   = 100,
    parameter int MEM_LAT    = 2,
    parameter int MAX_DIGITS = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op_sel,
    output logic              busy,
    input  logic              dig_valid,
    output logic              dig_ready,
    input  logic [3:0]        dig_a,
    input  logic [3:0]        dig_b,
    input  logic              dig_last,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [3:0]        mem_rd_data,
    output logic              res_valid,
    output logic [3:0]        res_digit,
    output logic              res_last,
    output logic              res_carry,
    output logic              res_neg
);
    localparam int CNT_W = $clog2(MAX_DIGITS + 1);
    localparam int IW    = (MAX_DIGITS > 1) ? $clog2(MAX_DIGITS) : 1;

    st_e  state_q, state_n;
    op_e  op_q;
    ph_e  ph_q;
    lk_e  lk_kind_q;
    logic [3:0] lk_x_q, lk_y_q, rdata_q, carry_q, part_q, hi_q;
    logic [3:0] res_d_q;
    logic       c1_q, last_q, tail_q, neg_q;
    logic       res_last_q, res_carry_q, res_neg_q;
    logic [CNT_W-1:0] dcnt_q, oidx_q;

    logic       rd_pending, rd_done, wrap, start_ok, out_last;
    logic       st_we;
    logic [3:0] st_rdata;

    // a sum digit below its first operand means the lookup wrapped past nine
    assign wrap     = (rdata_q < lk_x_q);
    assign start_ok = start && (op_sel != 2'd3);
    assign out_last = ((oidx_q + 1'b1) == dcnt_q);
    assign st_we    = (state_q == ST_EVAL) && (ph_q == PH_CIN) && (op_q == OP_SUB);

    dlu_addr_gen #(.ADDR_W(ADDR_W), .ADD_BASE(ADD_BASE), .MUL_BASE(MUL_BASE)) i_addr (
        .kind (lk_kind_q),
        .x    (lk_x_q),
        .y    (lk_y_q),
        .addr (mem_rd_addr)
    );

    dlu_rd_timer #(.LAT(MEM_LAT)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (mem_rd_en),
        .pending (rd_pending),
        .done    (rd_done)
    );

    dlu_digit_store #(.DEPTH(MAX_DIGITS)) i_store (
        .clk   (clk),
        .we    (st_we),
        .widx  (dcnt_q[IW-1:0]),
        .wdata (rdata_q),
        .ridx  (oidx_q[IW-1:0]),
        .rdata (st_rdata)
    );

    // next-state decision
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (start_ok) state_n = ST_GET;
            ST_GET:  if (dig_valid) state_n = ST_RD;
            ST_RD:   state_n = ST_WAIT;
            ST_WAIT: if (rd_done) state_n = ST_EVAL;
            ST_EVAL: begin
                unique case (ph_q)
                    PH_SUM, PH_MLO, PH_MHI, PH_MCIN: state_n = ST_RD;
                    PH_CIN:  state_n = (op_q == OP_SUB) ? (last_q ? ST_SOUT : ST_GET) : ST_PUT;
                    default: state_n = ST_PUT;
                endcase
            end
            ST_SOUT: state_n = neg_q ? ST_RD : ST_PUT;
            ST_PUT: begin
                if (tail_q)              state_n = ST_PUT;
                else if (res_last_q)     state_n = ST_IDLE;
                else if (op_q == OP_SUB) state_n = ST_SOUT;
                else                     state_n = ST_GET;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // datapath registers, advanced per state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q        <= OP_ADD;
            ph_q        <= PH_SUM;
            lk_kind_q   <= LK_SUM;
            lk_x_q      <= '0;
            lk_y_q      <= '0;
            rdata_q     <= '0;
            carry_q     <= '0;
            part_q      <= '0;
            hi_q        <= '0;
            res_d_q     <= '0;
            c1_q        <= 1'b0;
            last_q      <= 1'b0;
            tail_q      <= 1'b0;
            neg_q       <= 1'b0;
            res_last_q  <= 1'b0;
            res_carry_q <= 1'b0;
            res_neg_q   <= 1'b0;
            dcnt_q      <= '0;
            oidx_q      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_ok) begin
                    op_q    <= op_e'(op_sel);
                    carry_q <= (op_sel == 2'd1) ? 4'd1 : 4'd0;
                    dcnt_q  <= '0;
                    oidx_q  <= '0;
                    tail_q  <= 1'b0;
                    neg_q   <= 1'b0;
                end
                ST_GET: if (dig_valid) begin
                    lk_x_q <= dig_a;
                    lk_y_q <= (op_q == OP_SUB) ? (DIGIT_TOP - dig_b) : dig_b;
                    last_q <= dig_last || (dcnt_q == CNT_W'(MAX_DIGITS - 1));
                    if (op_q == OP_MUL) begin
                        ph_q      <= PH_MLO;
                        lk_kind_q <= LK_PLO;
                    end else begin
                        ph_q      <= PH_SUM;
                        lk_kind_q <= LK_SUM;
                    end
                end
                ST_WAIT: if (rd_done) rdata_q <= mem_rd_data;
                ST_EVAL: begin
                    unique case (ph_q)
                        PH_SUM: begin
                            c1_q   <= wrap;
                            lk_x_q <= rdata_q;
                            lk_y_q <= carry_q;
                            ph_q   <= PH_CIN;
                        end
                        PH_CIN: begin
                            carry_q <= {3'b000, c1_q | wrap};
                            dcnt_q  <= dcnt_q + 1'b1;
                            if (op_q == OP_SUB) begin
                                if (last_q) begin
                                    neg_q   <= !(c1_q | wrap);
                                    oidx_q  <= '0;
                                    carry_q <= 4'd1;
                                end
                            end else begin
                                res_d_q     <= rdata_q;
                                res_last_q  <= last_q;
                                res_carry_q <= last_q & (c1_q | wrap);
                                res_neg_q   <= 1'b0;
                            end
                        end
                        PH_MLO: begin
                            part_q    <= rdata_q;
                            lk_kind_q <= LK_PHI;
                            ph_q      <= PH_MHI;
                        end
                        PH_MHI: begin
                            hi_q      <= rdata_q;
                            lk_kind_q <= LK_SUM;
                            lk_x_q    <= part_q;
                            lk_y_q    <= carry_q;
                            ph_q      <= PH_MCIN;
                        end
                        PH_MCIN: begin
                            part_q <= rdata_q;
                            lk_x_q <= hi_q;
                            lk_y_q <= {3'b000, wrap};
                            ph_q   <= PH_MCY;
                        end
                        PH_MCY: begin
                            carry_q     <= rdata_q;
                            dcnt_q      <= dcnt_q + 1'b1;
                            res_d_q     <= part_q;
                            res_last_q  <= 1'b0;
                            res_carry_q <= 1'b0;
                            res_neg_q   <= 1'b0;
                            tail_q      <= last_q;
                        end
                        default: begin
                            carry_q     <= {3'b000, wrap};
                            res_d_q     <= rdata_q;
                            res_neg_q   <= 1'b1;
                            res_carry_q <= 1'b0;
                            res_last_q  <= out_last;
                        end
                    endcase
                end
                ST_SOUT: begin
                    if (neg_q) begin
                        lk_kind_q <= LK_SUM;
                        lk_x_q    <= DIGIT_TOP - st_rdata;
                        lk_y_q    <= carry_q;
                        ph_q      <= PH_FIX;
                    end else begin
                        res_d_q     <= st_rdata;
                        res_neg_q   <= 1'b0;
                        res_carry_q <= 1'b0;
                        res_last_q  <= out_last;
                    end
                end
                ST_PUT: begin
                    if (tail_q) begin
                        res_d_q    <= carry_q;
                        res_last_q <= 1'b1;
                        tail_q     <= 1'b0;
                    end else if (!res_last_q && op_q == OP_SUB) begin
                        oidx_q <= oidx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        busy      = (state_q != ST_IDLE);
        dig_ready = (state_q == ST_GET);
        mem_rd_en = (state_q == ST_RD);
        res_valid = (state_q == ST_PUT);
        res_digit = res_d_q;
        res_last  = res_last_q;
        res_carry = res_carry_q;
        res_neg   = res_neg_q;
    end

    // R2
    sum_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && lk_kind_q == LK_SUM) |->
        (mem_rd_addr >= ADDR_W'(ADD_BASE) && mem_rd_addr <= ADDR_W'(ADD_BASE + 99)));

    // R3
    prod_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && lk_kind_q != LK_SUM) |->
        (mem_rd_addr >= ADDR_W'(MUL_BASE) && mem_rd_addr <= ADDR_W'(MUL_BASE + 199)));

    // R10
    ready_idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dig_ready |-> !rd_pending);

    // R12
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_digit <= DIGIT_TOP));

    // R9
    result_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy);

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (op_q == $past(op_q)));

    // R11
    field_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dig_ready |-> (dcnt_q < CNT_W'(MAX_DIGITS)));
endmodule

// File: tb/test_lut_decimal_alu.sv
module test_lut_decimal_alu;
    localparam int ADDR_W = 15;
    localparam int MEM_LAT = 2;
    localparam int MAXD = 8;
    localparam int MEMSZ = 400;
    localparam int RMAX = 512;
    localparam int NV = 12;

    // vector table: operation, field length, operand a, operand b
    localparam int VOP [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 1, 2, 2, 2};
    localparam int VN  [NV] = '{1, 4, 3, 2, 1, 4, 3, 5, 4, 3, 4, 2};
    localparam int VA  [NV] = '{7, 4567, 999, 12, 3, 5000, 123, 10000, 123, 507, 9999, 0};
    localparam int VB  [NV] = '{5, 5678, 1, 34, 5, 1, 123, 1, 4567, 7, 9, 9};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] op_sel = 2'd0;
    logic busy;
    logic dig_valid = 1'b0;
    logic dig_ready;
    logic [3:0] dig_a = 4'd0;
    logic [3:0] dig_b = 4'd0;
    logic dig_last = 1'b0;
    logic mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [3:0] mem_rd_data;
    logic res_valid;
    logic [3:0] res_digit;
    logic res_last, res_carry, res_neg;

    always #4 clk = ~clk;

    lut_decimal_alu #(.ADDR_W(ADDR_W), .MEM_LAT(MEM_LAT), .MAX_DIGITS(MAXD)) i_lut_decimal_alu (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .busy(busy),
        .dig_valid(dig_valid), .dig_ready(dig_ready), .dig_a(dig_a), .dig_b(dig_b),
        .dig_last(dig_last), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .res_valid(res_valid), .res_digit(res_digit),
        .res_last(res_last), .res_carry(res_carry), .res_neg(res_neg)
    );

    // core memory model with a fixed read latency; idle cycles return 4'hF
    logic [3:0] core [MEMSZ];
    logic [3:0] pipe [MEM_LAT];
    always @(posedge clk) begin
        for (int i = MEM_LAT - 1; i > 0; i--) pipe[i] <= pipe[i-1];
        pipe[0] <= (mem_rd_en && mem_rd_addr < MEMSZ) ? core[mem_rd_addr] : 4'hF;
    end
    assign mem_rd_data = pipe[MEM_LAT-1];

    // result collector
    int rcount = 0;
    logic [3:0] rdig [RMAX];
    logic rlast [RMAX];
    logic rneg [RMAX];
    logic rcar [RMAX];
    always @(negedge clk) begin
        if (res_valid && rcount < RMAX) begin
            rdig[rcount] = res_digit;
            rlast[rcount] = res_last;
            rneg[rcount] = res_neg;
            rcar[rcount] = res_carry;
            rcount = rcount + 1;
        end
    end

    int n_checks = 0;
    int n_fail = 0;

    task automatic check_eq(input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic longint pow10(input int n);
        longint p = 1;
        for (int k = 0; k < n; k++) p = p * 10;
        return p;
    endfunction

    function automatic int dg(input longint v, input int i);
        return int'((v / pow10(i)) % 10);
    endfunction

    task automatic run_op(input int op, input int n, input int a_val, input int b_val,
                          input bit use_last, input bit poke);
        int base;
        int nres;
        longint val;
        longint lim;
        bit e_neg;
        bit e_car;
        string tag;
        base = rcount;
        e_neg = 1'b0;
        e_car = 1'b0;
        lim = pow10(n);
        @(negedge clk);
        op_sel = 2'(op);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R9 busy after start", longint'(busy), 1);
        for (int i = 0; i < n; i++) begin
            dig_valid = 1'b1;
            dig_a = 4'(dg(a_val, i));
            dig_b = (op == 2) ? 4'(b_val) : 4'(dg(b_val, i));
            dig_last = use_last && (i == n - 1);
            while (!dig_ready) @(negedge clk);
            if (poke && i == 1) begin
                start = 1'b1;
                op_sel = 2'd2;
            end
            @(negedge clk);
            start = 1'b0;
        end
        dig_valid = 1'b0;
        dig_last = 1'b0;
        while (busy) @(negedge clk);
        if (op == 0) begin
            val = longint'(a_val) + longint'(b_val);
            e_car = (val >= lim);
            val = val % lim;
            nres = n;
            tag = "R2 R4";
        end else if (op == 1) begin
            val = longint'(a_val) - longint'(b_val);
            e_neg = (val < 0);
            if (e_neg) val = -val;
            nres = n;
            tag = e_neg ? "R6" : "R5";
        end else begin
            val = longint'(a_val) * longint'(b_val);
            nres = n + 1;
            tag = "R3 R7";
        end
        check_eq({tag, " R10 result count"}, longint'(rcount - base), longint'(nres));
        for (int k = 0; k < nres && base + k < RMAX; k++) begin
            check_eq({tag, " R8 R12 digit"}, longint'(rdig[base+k]), longint'(dg(val, k)));
            check_eq({tag, " R12 last flag"}, longint'(rlast[base+k]), longint'(k == nres - 1));
            check_eq({tag, " R6 sign flag"}, longint'(rneg[base+k]), longint'(e_neg));
            check_eq({tag, " R4 carry flag"}, longint'(rcar[base+k]), longint'(e_car && k == nres - 1));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hang, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int cnt;
        for (int i = 0; i < MEMSZ; i++) core[i] = 4'd0;
        for (int a = 0; a < 10; a++) begin
            for (int b = 0; b < 10; b++) begin
                core[300 + 10*a + b] = 4'((a + b) % 10);
                core[100 + 2*(10*a + b)] = 4'((a * b) % 10);
                core[101 + 2*(10*a + b)] = 4'((a * b) / 10);
            end
        end
        for (int i = 0; i < MEM_LAT; i++) pipe[i] = 4'd0;

        repeat (3) @(negedge clk);
        // R1 reset state
        check_eq("R1 busy in reset", longint'(busy), 0);
        check_eq("R1 ready in reset", longint'(dig_ready), 0);
        check_eq("R1 read in reset", longint'(mem_rd_en), 0);
        check_eq("R1 result in reset", longint'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 busy after reset", longint'(busy), 0);

        // vector table
        for (int v = 0; v < NV; v++) run_op(VOP[v], VN[v], VA[v], VB[v], 1'b1, 1'b0);

        // R9: code 3 start is ignored
        @(negedge clk);
        op_sel = 2'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_eq("R9 code 3 start ignored", longint'(busy), 0);
        @(negedge clk);
        check_eq("R9 code 3 no ready", longint'(dig_ready), 0);

        // R9: start pulse during an add does not disturb it
        run_op(0, 2, 58, 64, 1'b1, 1'b1);
        check_eq("R9 idle after poked add", longint'(busy), 0);

        // R11: full-length field without the end flag
        cnt = rcount;
        run_op(0, MAXD, 12345678, 11111111, 1'b0, 1'b0);
        check_eq("R11 field closed at limit", longint'(rcount - cnt), longint'(MAXD));
        @(negedge clk);
        check_eq("R11 no ready after limit", longint'(dig_ready), 0);

        // R11 with subtraction going negative at full length
        run_op(1, MAXD, 1, 2, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule